// File: doc/BRIEF.md
# Memory Card Slot Status and Insertion Interrupt Register

This block is a small board-control register slice for one memory card slot. It watches two slot signals: a write-protect level, and a card-insertion event line. It offers their state to software over a 32-bit, word-addressed register bus, and it raises a single interrupt line when a card is inserted. The same window also holds a fixed identification word and a fixed decode word. A flash-programming control word accepts writes without effect.

Write-protect is reported live: the bit shows the level present at the read. Insertion is sticky. Once the event line is seen high, the insertion bit stays set and the interrupt stays asserted, even after the line falls. It clears only when software writes a one to that bit of the status word. An insertion that arrives in the same cycle as a clear write is kept, so no card event is lost.

Reads are registered. Read data appears one clock after the address is presented. The interrupt output is driven straight from a flop.

Top module: `cardslot_ctl`

## Requirements
- R1: Bit 0 of the status word (word index 2) reads the level that the write-protect input had at the clock edge that captured the read.
- R2: A high level on the insertion input sets bit 3 of the status word and asserts the interrupt on the next clock edge. Both stay set after the input returns low.
- R3: A write to word 2 with bit 3 of the write data at one clears bit 3, and the interrupt drops on the next edge. A write to word 2 with bit 3 at zero changes nothing, whatever its other bits hold.
- R4: Word 0 reads 0x41034003, word 1 reads 0x00000000 and word 3 reads 0x00000011. The status word reads zero in every bit other than 0 and 3.
- R5: Writes to word 1, word 3 and every word index of 4 or above leave the status bits and the interrupt unchanged. Reads of word index 4 or above return zero.
- R6: An insertion event and a clearing write in the same cycle leave bit 3 set and the interrupt asserted.
- R7: While reset is high, and in the first cycle after it, the interrupt is low, bit 3 of the status word is zero and the read data is zero.
- R8: The read data bus shows the word selected by the address presented at the previous clock edge. The result is the same whether or not a write strobe accompanies that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_level_i | input | 1 | Card write-protect level from the slot |
| insert_evt_i | input | 1 | Card insertion event, high while a card is being detected |
| bus_addr_i | input | ADDR_W (6) | Word address of the register access |
| bus_wr_i | input | 1 | Write strobe for the addressed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Card insertion interrupt, level, active high |

## Verification
The only state held here is the sticky insertion bit. A wrong value of it shows at `irq_o` in the very next cycle, and in bit 3 of a status read one cycle after the read address. A lost set, a spurious clear, or a clear taken from the wrong word or bit is therefore visible within one or two clocks of the access that caused it. Errors in the address decode or the read multiplexer show as a wrong constant or a nonzero value on the read data bus, one cycle after the address. The bench tracks the expected insertion bit and every read word cycle by cycle, so each such divergence is reported at the cycle where it first appears.

// File: rtl/cardslot_pkg.sv
package cardslot_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned NUM_WORDS   = 4;
  localparam int unsigned WIDX_IDENT  = 0;
  localparam int unsigned WIDX_FLASH  = 1;
  localparam int unsigned WIDX_STATUS = 2;
  localparam int unsigned WIDX_DECODE = 3;
  localparam int unsigned WP_BIT      = 0;
  localparam int unsigned CARD_BIT    = 3;
  localparam logic [DATA_W-1:0] IDENT_VALUE  = 32'h4103_4003;
  localparam logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011;

  typedef logic [NUM_WORDS-1:0] word_sel_t;
endpackage

// File: rtl/cardslot_decode.sv
module cardslot_decode
  import cardslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output word_sel_t         sel_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
    assign sel_o[w] = (addr_i == ADDR_W'(w));
  end
endmodule

// File: rtl/cardslot_status.sv
module cardslot_status #(
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_q
);
  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= RESET_VAL;
    else if (set_i)   flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/cardslot_rdmux.sv
module cardslot_rdmux
  import cardslot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  word_sel_t         sel_i,
  input  logic              wp_i,
  input  logic              card_i,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] next_rdata;

  always_comb begin
    status_word           = '0;
    status_word[WP_BIT]   = wp_i;
    status_word[CARD_BIT] = card_i;
  end

  always_comb begin
    next_rdata = '0;
    if (sel_i[WIDX_IDENT])  next_rdata = IDENT_VALUE;
    if (sel_i[WIDX_STATUS]) next_rdata = status_word;
    if (sel_i[WIDX_DECODE]) next_rdata = DECODE_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= next_rdata;
  end
endmodule

// File: rtl/cardslot_ctl.sv
module cardslot_ctl
  import cardslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_level_i,
  input  logic              insert_evt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  word_sel_t sel;
  logic      clear_req;
  logic      card_q;
  logic      unused_wdata_bits;

  assign unused_wdata_bits = ^bus_wdata_i;

  cardslot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign clear_req = bus_wr_i & sel[WIDX_STATUS] & bus_wdata_i[CARD_BIT];

  cardslot_status #(.RESET_VAL(1'b0)) u_card (
    .clk     (clk),
    .rst     (rst),
    .set_i   (insert_evt_i),
    .clear_i (clear_req),
    .flag_q  (card_q)
  );

  cardslot_rdmux u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel),
    .wp_i    (wp_level_i),
    .card_i  (card_q),
    .rdata_q (bus_rdata_o)
  );

  assign irq_o = card_q;
endmodule

// File: rtl/cardslot_ctl_chk.sv
module cardslot_ctl_chk
  import cardslot_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wp_level_i,
  input logic              insert_evt_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o
);
  logic clr_wr;
  assign clr_wr = bus_wr_i && (bus_addr_i == ADDR_W'(WIDX_STATUS)) && bus_wdata_i[CARD_BIT];

  p_wp_live_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == ADDR_W'(WIDX_STATUS)) |=> (bus_rdata_o[WP_BIT] == $past(wp_level_i)));

  p_insert_sets_r2: assert property (@(posedge clk) disable iff (rst)
    insert_evt_i |=> irq_o);

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_wr) |=> irq_o);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !insert_evt_i) |=> !irq_o);

  p_ident_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == ADDR_W'(WIDX_IDENT)) |=> (bus_rdata_o == IDENT_VALUE));

  p_decode_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == ADDR_W'(WIDX_DECODE)) |=> (bus_rdata_o == DECODE_VALUE));

  p_hole_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i >= ADDR_W'(NUM_WORDS)) |=> (bus_rdata_o == '0));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !insert_evt_i) |=> !irq_o);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (insert_evt_i && clr_wr) |=> irq_o);

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (!irq_o && bus_rdata_o == '0));
endmodule

bind cardslot_ctl cardslot_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cardslot_ctl_tb_top.sv
`timescale 1ns/1ps
module cardslot_ctl_tb_top;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp = 1'b0;
  logic          ins = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit card_m = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cardslot_ctl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wp_level_i(wp), .insert_evt_i(ins),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(logic [AW-1:0] a, bit w, bit c);
    case (a)
      0: return 32'h4103_4003;
      2: return {28'd0, c, 2'b00, w};
      3: return 32'h0000_0011;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then check outputs just after the edge
  task automatic step(bit w, bit i, bit we, logic [AW-1:0] a, logic [31:0] d, string rtag);
    logic [31:0] er;
    bit clr;
    string itag;
    wp = w; ins = i; wr = we; addr = a; wdata = d;
    er  = exp_read(a, w, card_m);
    clr = we && (a == 2) && d[3];
    if (i && clr)      itag = "R6";
    else if (i)        itag = "R2";
    else if (clr)      itag = "R3";
    else               itag = "R5";
    if (i) card_m = 1'b1;
    else if (clr) card_m = 1'b0;
    @(posedge clk); #1;
    check(rtag, rdata, er);
    check(itag, {31'd0, irq}, {31'd0, card_m});
  endtask

  function automatic string read_tag(logic [AW-1:0] a);
    if (a == 2) return "R1";
    if (a < 4)  return "R4";
    return "R5";
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1;
    check("R7", rdata, 32'd0);
    check("R7", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    // R7: first cycle after reset, status read shows bit 3 clear
    step(1, 0, 0, 2, 0, "R7");
    // R4 constants
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 3, 0, "R4");
    // R2 insertion, then input low: stays set
    step(0, 1, 0, 5, 0, "R5");
    step(1, 0, 0, 2, 0, "R2");
    step(0, 0, 0, 2, 0, "R2");
    // R3 write with bit 3 zero: no effect
    step(0, 0, 1, 2, 32'hFFFF_FFF7, "R3");
    // R5 writes to other words: no effect
    step(0, 0, 1, 1, 32'hFFFF_FFFF, "R5");
    step(0, 0, 1, 3, 32'hFFFF_FFFF, "R5");
    step(0, 0, 1, 9, 32'hFFFF_FFFF, "R5");
    // R3 clearing write
    step(0, 0, 1, 2, 32'h0000_0008, "R3");
    step(0, 0, 0, 2, 0, "R3");
    // R6 set wins over clear
    step(0, 1, 1, 2, 32'h0000_0008, "R6");
    step(0, 0, 0, 2, 0, "R6");
    // R8 pipeline: address order reflected one cycle later, with write strobe
    step(1, 0, 1, 0, 32'h0, "R8");
    step(1, 0, 1, 63, 32'h0, "R8");
    step(1, 0, 0, 2, 0, "R8");
    // constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a;
      bit r_ins, r_wr;
      logic [31:0] d;
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 5);
      r_ins = ($urandom % 10 == 0);
      r_wr  = ($urandom % 2 == 0);
      d = $urandom;
      if ($urandom % 3 == 0) d[3] = 1'b1;
      step(bit'($urandom % 2), r_ins, r_wr, a, d, read_tag(a));
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule